// File: doc/BRIEF.md
# Preamble Framer with Rate-1/2 Convolutional Encoder

This block turns a serial stream of payload bits into fixed-length transmit packets. Payload bits arrive one per cycle under a valid/ready handshake and are collected into a block store. Once a whole block of 60 bits is held, the next bit strobe launches a packet. The packet opens with a fixed 6-bit sync pattern. The block's bits then follow, run through a rate-1/2, two-tap convolutional code that is flushed with one zero bit.

The output side is paced by an external bit strobe. Each strobe moves the serial output one bit along a 128-bit frame. A start flag marks the first bit of a frame, and a second flag marks the sync-pattern bits. While one packet is being sent, the store can already fill with the next block, so packets can run back to back without a gap.

Top module: `coded_frame_tx`

## Requirements
- R1: Every packet spans exactly 128 consecutive strobe-updated output bits: 6 sync bits followed by 122 coded bits. When a block is ready at the end of a packet, the next packet's first bit comes on the very next strobe.
- R2: The first 6 bits of a packet are 1,0,1,0,1,1 in that order, with `out_pre`=1 on each of them. `out_sop`=1 on the first bit only.
- R3: Take the data bits d0..d59 in arrival order, set d60=0 and d(-1)=0. For each k from 0 to 60 the code emits first d(k) xor d(k-1) and then d(k). This gives 122 coded bits with `out_pre`=0.
- R4: `in_ready` is 0 while 60 bits are stored and no packet has taken them. Bits offered while `in_ready`=0 are not stored.
- R5: A packet starts only on a strobe at which a full block is stored. A strobe with no packet in progress and no full block drives `out_bit`, `out_sop` and `out_pre` to 0.
- R6: The encoder memory is cleared at every packet start. The first coded bit of each packet equals d0 of that packet, whatever the previous packet held.
- R7: `out_bit`, `out_sop` and `out_pre` change only at a clock edge where `bit_stb` is 1. The new value is visible after that edge.
- R8: While a packet is being sent, the store accepts the next block, so packets can follow one another with no idle bit between them.
- R9: After reset the outputs are 0. `in_ready` is 1 once the reset release has passed two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_bit | input | 1 | Payload bit |
| in_valid | input | 1 | Payload bit offered |
| in_ready | output | 1 | Block store can take a bit |
| bit_stb | input | 1 | Advance the serial output by one bit |
| out_bit | output | 1 | Serial packet bit |
| out_sop | output | 1 | First bit of a packet |
| out_pre | output | 1 | Current bit belongs to the sync pattern |

## Verification
Two functions can fall in the same cycle: accepting a payload bit for the next block, and a strobe that advances or ends the current packet. The case that matters most is a block that completes just as the last coded bit of a packet leaves, so that the following strobe must load it and start a new packet at once. The bench provokes this with runs of continuous strobes and continuous valid input, and mixes in random strobe and valid densities. Every strobe-updated output is judged against a bench model built from the frame rules, and the strobe spacing between start flags of back-to-back packets is checked to be 128.

// File: rtl/cfr_pkg.sv
package cfr_pkg;
  // Which part of the frame the serial output is carrying
  typedef enum logic [1:0] {
    SEG_IDLE = 2'd0,
    SEG_PRE  = 2'd1,
    SEG_CODE = 2'd2
  } seg_e;
endpackage

// File: rtl/cfr_rst_sync.sv
module cfr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/cfr_blk_store.sv
module cfr_blk_store #(
  parameter int DATA_BITS = 60,
  parameter int KW        = $clog2(DATA_BITS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_bit,
  input  logic          load,
  input  logic [KW-1:0] rd_idx,
  output logic          full,
  output logic          rd_bit
);
  logic [DATA_BITS-1:0] fill_q, fill_n;
  logic [DATA_BITS-1:0] tx_q, tx_n;
  logic [KW-1:0]        cnt_q, cnt_n;

  assign full = (cnt_q == KW'(DATA_BITS));

  // positions past the stored block read as the zero flush bit
  assign rd_bit = (rd_idx < KW'(DATA_BITS)) ? tx_q[rd_idx] : 1'b0;

  always_comb begin
    fill_n = fill_q;
    tx_n   = tx_q;
    cnt_n  = cnt_q;
    if (load) begin
      tx_n  = fill_q;
      cnt_n = '0;
    end
    if (wr_en) begin
      fill_n[cnt_q] = wr_bit;
      cnt_n         = cnt_q + KW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  // data registers carry no reset; the count guards their use
  always_ff @(posedge clk) begin
    fill_q <= fill_n;
    tx_q   <= tx_n;
  end
endmodule

// File: rtl/cfr_conv_enc.sv
module cfr_conv_enc #(
  parameter logic [1:0] TAP_A = 2'b11,
  parameter logic [1:0] TAP_B = 2'b10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step_en,
  input  logic half,
  input  logic u,
  output logic c_out
);
  logic st_q, st_n;
  logic [1:0] win;

  assign win   = {u, st_q};
  assign c_out = half ? ^(TAP_B & win) : ^(TAP_A & win);

  always_comb begin
    st_n = st_q;
    if (clr)                  st_n = 1'b0;
    else if (step_en && half) st_n = u;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= 1'b0;
    else        st_q <= st_n;
  end
endmodule

// File: rtl/cfr_seq.sv
module cfr_seq #(
  parameter int FRAME_BITS = 128,
  parameter int PW         = $clog2(FRAME_BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_stb,
  input  logic          blk_full,
  output logic          start,
  output logic          emit,
  output logic [PW-1:0] cur_pos
);
  logic          act_q, act_n;
  logic [PW-1:0] pos_q, pos_n;
  logic          adv;

  assign start   = bit_stb && !act_q && blk_full;
  assign adv     = bit_stb && act_q;
  assign emit    = start || adv;
  assign cur_pos = act_q ? pos_q : '0;

  always_comb begin
    act_n = act_q;
    pos_n = pos_q;
    if (start) begin
      act_n = 1'b1;
      pos_n = PW'(1);
    end else if (adv) begin
      if (pos_q == PW'(FRAME_BITS - 1)) begin
        act_n = 1'b0;
        pos_n = '0;
      end else begin
        pos_n = pos_q + PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      pos_q <= '0;
    end else begin
      act_q <= act_n;
      pos_q <= pos_n;
    end
  end
endmodule

// File: rtl/coded_frame_tx.sv
module coded_frame_tx
  import cfr_pkg::*;
#(
  parameter int                 DATA_BITS = 60,
  parameter int                 PRE_LEN   = 6,
  parameter logic [PRE_LEN-1:0] PRE_PAT   = 6'b101011,
  parameter logic [1:0]         TAP_A     = 2'b11,
  parameter logic [1:0]         TAP_B     = 2'b10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_bit,
  input  logic in_valid,
  output logic in_ready,
  input  logic bit_stb,
  output logic out_bit,
  output logic out_sop,
  output logic out_pre
);
  localparam int CODE_BITS  = 2 * (DATA_BITS + 1);
  localparam int FRAME_BITS = PRE_LEN + CODE_BITS;
  localparam int PW         = $clog2(FRAME_BITS);
  localparam int KW         = $clog2(DATA_BITS + 1);

  logic          rst_sn;
  logic          full, rd_bit, wr_en;
  logic          start, emit;
  logic [PW-1:0] cur_pos, code_idx;
  logic [KW-1:0] rd_idx;
  logic          half, pre_bit, code_bit;
  seg_e          seg;
  logic          bit_n, sop_n, pre_n;

  cfr_rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_sn(rst_sn)
  );

  assign in_ready = !full && rst_sn;
  assign wr_en    = in_valid && in_ready;

  cfr_blk_store #(.DATA_BITS(DATA_BITS), .KW(KW)) u_store (
    .clk   (clk),
    .rst_n (rst_sn),
    .wr_en (wr_en),
    .wr_bit(in_bit),
    .load  (start),
    .rd_idx(rd_idx),
    .full  (full),
    .rd_bit(rd_bit)
  );

  cfr_seq #(.FRAME_BITS(FRAME_BITS), .PW(PW)) u_seq (
    .clk     (clk),
    .rst_n   (rst_sn),
    .bit_stb (bit_stb),
    .blk_full(full),
    .start   (start),
    .emit    (emit),
    .cur_pos (cur_pos)
  );

  assign seg      = !emit ? SEG_IDLE :
                    (cur_pos < PW'(PRE_LEN)) ? SEG_PRE : SEG_CODE;
  assign code_idx = cur_pos - PW'(PRE_LEN);
  assign rd_idx   = KW'(code_idx >> 1);
  assign half     = code_idx[0];

  always_comb begin
    pre_bit = 1'b0;
    for (int i = 0; i < PRE_LEN; i++) begin
      if (cur_pos == PW'(i)) pre_bit = PRE_PAT[PRE_LEN-1-i];
    end
  end

  cfr_conv_enc #(.TAP_A(TAP_A), .TAP_B(TAP_B)) u_enc (
    .clk    (clk),
    .rst_n  (rst_sn),
    .clr    (start),
    .step_en(seg == SEG_CODE),
    .half   (half),
    .u      (rd_bit),
    .c_out  (code_bit)
  );

  always_comb begin
    bit_n = 1'b0;
    sop_n = 1'b0;
    pre_n = 1'b0;
    case (seg)
      SEG_PRE: begin
        bit_n = pre_bit;
        sop_n = start;
        pre_n = 1'b1;
      end
      SEG_CODE: bit_n = code_bit;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      out_bit <= 1'b0;
      out_sop <= 1'b0;
      out_pre <= 1'b0;
    end else if (bit_stb) begin
      out_bit <= bit_n;
      out_sop <= sop_n;
      out_pre <= pre_n;
    end
  end
endmodule

// File: rtl/cfr_checker.sv
module cfr_checker #(
  parameter int DATA_BITS = 60
) (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic bit_stb,
  input logic out_bit,
  input logic out_sop,
  input logic out_pre
);
  localparam int AW = $clog2(DATA_BITS + 1) + 1;

  logic [AW-1:0] acc_q;
  logic          sop_d;
  logic          sop_new;

  assign sop_new = out_sop && !sop_d;

  // bits taken into the store minus bits handed to started packets
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      sop_d <= 1'b0;
    end else begin
      sop_d <= out_sop;
      acc_q <= acc_q + AW'(in_valid && in_ready) - (sop_new ? AW'(DATA_BITS) : AW'(0));
    end
  end

  p_ready_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q == AW'(DATA_BITS) && !sop_new) |-> !in_ready);

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q <= AW'(DATA_BITS));

  p_start_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sop_new |-> acc_q == AW'(DATA_BITS));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_stb |=> $stable({out_bit, out_sop, out_pre}));

  p_sop_head_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_sop |-> (out_pre && out_bit));

  p_pre_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_pre && !out_sop) |-> $past(out_pre));
endmodule

bind coded_frame_tx cfr_checker #(.DATA_BITS(DATA_BITS)) u_cfr_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .in_valid(in_valid),
  .in_ready(in_ready),
  .bit_stb (bit_stb),
  .out_bit (out_bit),
  .out_sop (out_sop),
  .out_pre (out_pre)
);

// File: tb/coded_frame_tx_bench.sv
module coded_frame_tx_bench;
  localparam int DB    = 60;
  localparam int PL    = 6;
  localparam int FRAME = PL + 2 * (DB + 1);

  logic clk, rst_n, in_bit, in_valid, in_ready, bit_stb;
  logic out_bit, out_sop, out_pre;

  int total, bad;
  bit done;

  // requirement model
  bit    m_fill [DB];
  bit    m_tx   [DB];
  int    m_cnt, m_pos, m_b2b;
  bit    m_act, m_last_end, m_sop_b2b;
  bit    e_bit, e_sop, e_pre;
  string e_tag;
  bit    alt;
  int    gap;
  bit    seen_sop, prev_stb;

  coded_frame_tx u_coded_frame_tx (
    .clk(clk), .rst_n(rst_n), .in_bit(in_bit), .in_valid(in_valid),
    .in_ready(in_ready), .bit_stb(bit_stb), .out_bit(out_bit),
    .out_sop(out_sop), .out_pre(out_pre)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit sync_bit(input int p);
    bit [5:0] pat = 6'b101011;
    return pat[5-p];
  endfunction

  function automatic bit data_at(input int k);
    if (k < 0 || k >= DB) return 1'b0;
    return m_tx[k];
  endfunction

  function automatic bit code_bit(input int p);
    int c = p - PL;
    int k = c / 2;
    if (c % 2 == 0) return data_at(k) ^ data_at(k - 1);
    return data_at(k);
  endfunction

  task automatic step(input int stb_pct, input int val_pct, input int mode);
    bit s, v, b, acc;
    @(negedge clk);
    // outputs after the previous edge
    chk({out_bit, out_sop, out_pre} == {e_bit, e_sop, e_pre}, e_tag,
        {out_bit, out_sop, out_pre}, {e_bit, e_sop, e_pre});
    chk(in_ready == (m_cnt < DB), "R4 ready", in_ready, m_cnt < DB);
    if (prev_stb) begin
      if (out_sop) begin
        if (seen_sop && m_sop_b2b) chk(gap == FRAME, "R1 frame length", gap, FRAME);
        seen_sop = 1'b1;
        gap = 1;
      end else begin
        gap++;
      end
    end
    s = ($urandom % 100) < stb_pct;
    v = ($urandom % 100) < val_pct;
    case (mode)
      1: b = 1'b1;
      2: b = 1'b0;
      3: begin alt = ~alt; b = alt; end
      default: b = $urandom % 2;
    endcase
    bit_stb = s; in_valid = v; in_bit = b;
    acc = v && in_ready;
    prev_stb = s;
    if (s) begin
      if (!m_act && m_cnt == DB) begin
        for (int i = 0; i < DB; i++) m_tx[i] = m_fill[i];
        m_cnt = 0; m_pos = 0; m_act = 1'b1;
        m_sop_b2b = m_last_end;
        if (m_last_end) m_b2b++;
      end
      m_last_end = 1'b0;
      if (m_act) begin
        e_sop = (m_pos == 0);
        e_pre = (m_pos < PL);
        e_bit = e_pre ? sync_bit(m_pos) : code_bit(m_pos);
        e_tag = e_pre ? "R2 sync" : (m_pos < PL + 2 ? "R6 first pair" : "R3 code");
        if (m_pos == FRAME - 1) begin m_act = 1'b0; m_last_end = 1'b1; end
        m_pos++;
      end else begin
        e_bit = 0; e_sop = 0; e_pre = 0; e_tag = "R5 idle";
      end
    end else begin
      e_tag = "R7 hold";
    end
    if (acc) begin
      m_fill[m_cnt] = b;
      m_cnt++;
    end
  endtask

  task automatic phase(input int n, input int stb_pct, input int val_pct, input int mode);
    for (int i = 0; i < n; i++) step(stb_pct, val_pct, mode);
  endtask

  initial begin
    total = 0; bad = 0; done = 1'b0;
    void'($urandom(32'd4021));
    rst_n = 1'b0; in_bit = 0; in_valid = 0; bit_stb = 0;
    m_cnt = 0; m_pos = 0; m_act = 0; m_last_end = 0; m_sop_b2b = 0; m_b2b = 0;
    e_bit = 0; e_sop = 0; e_pre = 0; e_tag = "R9 reset"; alt = 0;
    gap = 0; seen_sop = 0; prev_stb = 0;
    repeat (4) @(negedge clk);
    chk({out_bit, out_sop, out_pre} == 3'b000, "R9 outputs in reset", {out_bit, out_sop, out_pre}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R9 ready after reset", in_ready, 1);
    // fill with no strobe: store saturates, extra bits refused, outputs hold
    phase(90, 0, 100, 1);
    @(negedge clk);
    chk(in_ready == 1'b0, "R4 full store refuses", in_ready, 0);
    // one strobe launches the packet; extra offered bits must not appear
    phase(400, 100, 100, 3);
    phase(1500, 100, 100, 0);
    phase(2500, 35, 60, 0);
    phase(2000, 100, 8, 0);
    phase(1200, 70, 100, 2);
    phase(1500, 100, 100, 1);
    phase(3000, 50, 50, 0);
    phase(300, 0, 0, 0);
    chk(m_b2b > 0, "R8 back-to-back packets seen", m_b2b, 1);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule